// File: doc/BRIEF.md
# Coefficient-Major Token Slot Sequencer

This block produces the sequence of logical slot addresses for a frame-sized buffer of fixed-width coefficient tokens. Each 8x8 block of a 4:2:0 frame owns 64 consecutive slots, one per coefficient index. Blocks are grouped six to a 16x16 macroblock: four luma blocks followed by one Cb block and one Cr block. In write order the sequencer walks the slots linearly, which matches the order in which a block-by-block transform stage produces tokens. In read order it walks the same slots in the order a bitstream packer consumes them.

The read order has five nested levels. The outermost level is the coefficient index. Inside it come the planes. Inside each plane come 32x32-pixel superblocks of 4x4 blocks, scanned left to right and then bottom to top. Inside each superblock the blocks are visited along a fixed Hilbert path. Superblocks on the right and top edges can be partial, and their missing positions are skipped without a gap in the output. Along with every address the block gives the coefficient index and the plane, so that a downstream stage can choose its token tables. It also raises an end-of-frame flag with the last address. The frame size in macroblocks is set by parameters.

Top module: `token_order_agu`

## Requirements
- R1: After reset `valid` and `eof` are low, and they stay low until `start` is sampled high.
- R2: A `start` pulse is sampled only while the block is idle. A pulse during a frame changes neither the order nor the mode of the frame in progress.
- R3: In write order (`read_order`=0 at start) the addresses run 0, 1, 2 … up to the total slot count minus one. `coef_idx` is the address modulo 64. `plane` is 0 (Y) for block-in-macroblock 0–3, 1 (Cb) for block 4 and 2 (Cr) for block 5.
- R4: In read order `coef_idx` starts at 0 and never decreases. It rises by one only after the last Cr address of the previous index.
- R5: Within one coefficient index the planes appear as 0 (Y), then 1 (Cb), then 2 (Cr).
- R6: Luma has 2·MB_COLS × 2·MB_ROWS blocks. Block (x,y) has y counted from the bottom row. It maps to macroblock ((r/2)·MB_COLS + x/2) and block-in-macroblock 2·(r mod 2) + (x mod 2), where r = 2·MB_ROWS−1−y. Within a superblock the offsets (x,y) follow the order (0,0),(1,0),(1,1),(0,1),(0,2),(0,3),(1,3),(1,2),(2,2),(2,3),(3,3),(3,2),(3,1),(2,1),(2,0),(3,0). Superblocks are scanned left to right, then bottom to top.
- R7: Each chroma plane has MB_COLS × MB_ROWS blocks. Block (x,y) maps to macroblock ((MB_ROWS−1−y)·MB_COLS + x) and block-in-macroblock 4 for Cb or 5 for Cr. Superblocks and the Hilbert path are as in R6.
- R8: Positions of a superblock that fall outside the plane produce no address. The next in-plane position follows in the very next cycle.
- R9: While `valid` is high, one address is accepted on each clock edge with `ready` high. With `ready` low, all outputs hold.
- R10: `eof` is high only together with the last address of a frame. After that address is accepted, `valid` falls. Every frame delivers exactly MB_COLS·MB_ROWS·384 addresses.
- R11: Every address equals (macroblock·6 + block-in-macroblock)·64 + coefficient index, so each slot appears exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame when idle |
| read_order | input | 1 | Order for the frame being started: 0 write, 1 read |
| ready | input | 1 | Consumer accepts the current address |
| valid | output | 1 | An address is presented |
| slot_addr | output | clog2(MB_COLS·MB_ROWS·384) | Linear slot address |
| coef_idx | output | 6 | Coefficient index of the slot |
| plane | output | 2 | 0 Y, 1 Cb, 2 Cr |
| eof | output | 1 | Last address of the frame |

## Verification
Suppose a position counter or a plane-size selection goes wrong inside the read walker. The next accepted address then differs from the one the nested read order predicts, and every later address is shifted as well, so a bench that compares each handshake sees the error on the first bad slot. A faulty skip look-ahead shows up as a repeated or missing address at the edge of a partial superblock, or as `valid` staying high on an out-of-plane position. A wrong end condition shows up as `eof` on the wrong slot or as a frame whose total count is not the slot count.

// File: rtl/toa_pkg.sv
package toa_pkg;

   typedef enum logic [1:0] {
      PL_Y  = 2'd0,
      PL_CB = 2'd1,
      PL_CR = 2'd2
   } plane_e;

   localparam int unsigned COEF_PER_BLK = 64;
   localparam int unsigned BLK_PER_MB   = 6;
   localparam int unsigned SB_SPAN      = 4;

   // Offset of step h on the superblock path: {x[1:0], y[1:0]}, y from bottom.
   function automatic logic [3:0] hilbert_xy(input logic [3:0] h);
      logic [3:0] r;
      case (h)
         4'd0:  r = {2'd0, 2'd0};
         4'd1:  r = {2'd1, 2'd0};
         4'd2:  r = {2'd1, 2'd1};
         4'd3:  r = {2'd0, 2'd1};
         4'd4:  r = {2'd0, 2'd2};
         4'd5:  r = {2'd0, 2'd3};
         4'd6:  r = {2'd1, 2'd3};
         4'd7:  r = {2'd1, 2'd2};
         4'd8:  r = {2'd2, 2'd2};
         4'd9:  r = {2'd2, 2'd3};
         4'd10: r = {2'd3, 2'd3};
         4'd11: r = {2'd3, 2'd2};
         4'd12: r = {2'd3, 2'd1};
         4'd13: r = {2'd2, 2'd1};
         4'd14: r = {2'd2, 2'd0};
         default: r = {2'd3, 2'd0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/toa_write_walk.sv
module toa_write_walk
   import toa_pkg::*;
#(
   parameter int MB_TOTAL = 15,
   parameter int MB_IW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             step,
   output logic [MB_IW-1:0] mb,
   output logic [2:0]       sub,
   output logic [5:0]       coef,
   output plane_e           plane,
   output logic             last
);

   localparam logic [MB_IW-1:0] MB_LAST = MB_IW'(MB_TOTAL - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || init) begin
         mb   <= '0;
         sub  <= '0;
         coef <= '0;
      end else if (step) begin
         coef <= coef + 6'd1;
         if (coef == 6'd63) begin
            if (sub == 3'(BLK_PER_MB - 1)) begin
               sub <= '0;
               mb  <= (mb == MB_LAST) ? '0 : mb + 1'b1;
            end else begin
               sub <= sub + 3'd1;
            end
         end
      end
   end

   always_comb begin
      if (sub < 3'd4)       plane = PL_Y;
      else if (sub == 3'd4) plane = PL_CB;
      else                  plane = PL_CR;
      last = (coef == 6'd63) && (sub == 3'(BLK_PER_MB - 1)) && (mb == MB_LAST);
   end

   // R3: block-in-macroblock never leaves 0..5 while walking
   p_sub_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (sub < 3'(BLK_PER_MB)));

endmodule

// File: rtl/toa_read_walk.sv
module toa_read_walk
   import toa_pkg::*;
#(
   parameter int MB_COLS = 5,
   parameter int MB_ROWS = 3,
   parameter int XW      = 4,
   parameter int YW      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          step,
   output logic [5:0]    coef,
   output plane_e        plane,
   output logic [XW-1:0] bx,
   output logic [YW-1:0] by,
   output logic          last
);

   localparam int LUMA_W = 2 * MB_COLS;
   localparam int LUMA_H = 2 * MB_ROWS;
   localparam int LSB_X  = (LUMA_W + SB_SPAN - 1) / SB_SPAN;
   localparam int LSB_Y  = (LUMA_H + SB_SPAN - 1) / SB_SPAN;
   localparam int CSB_X  = (MB_COLS + SB_SPAN - 1) / SB_SPAN;
   localparam int CSB_Y  = (MB_ROWS + SB_SPAN - 1) / SB_SPAN;

   logic [XW-1:0] sbx;
   logic [YW-1:0] sby;
   logic [3:0]    h;
   int            pw, ph, nsx, nsy;
   logic [15:0]   h_ok;
   logic          has_next;
   logic [3:0]    h_next;
   logic          sb_last_x, sb_last_y;

   // size of the plane being walked
   always_comb begin
      if (plane == PL_Y) begin
         pw = LUMA_W;  ph = LUMA_H;  nsx = LSB_X;  nsy = LSB_Y;
      end else begin
         pw = MB_COLS; ph = MB_ROWS; nsx = CSB_X;  nsy = CSB_Y;
      end
   end

   // which path positions of the current superblock lie inside the plane
   for (genvar g = 0; g < 16; g++) begin : g_mask
      localparam logic [3:0] XY = hilbert_xy(4'(g));
      assign h_ok[g] = ((int'(sbx) * SB_SPAN + int'(XY[3:2])) < pw) &&
                       ((int'(sby) * SB_SPAN + int'(XY[1:0])) < ph);
   end

   // look-ahead: nearest later in-plane position in this superblock
   always_comb begin
      has_next = 1'b0;
      h_next   = '0;
      for (int i = 15; i >= 0; i--) begin
         if (i > int'(h) && h_ok[i]) begin
            has_next = 1'b1;
            h_next   = 4'(i);
         end
      end
   end

   assign sb_last_x = (int'(sbx) == nsx - 1);
   assign sb_last_y = (int'(sby) == nsy - 1);
   assign last = !has_next && sb_last_x && sb_last_y &&
                 (plane == PL_CR) && (coef == 6'd63);

   always_ff @(posedge clk) begin
      if (!rst_n || init) begin
         coef  <= '0;
         plane <= PL_Y;
         sbx   <= '0;
         sby   <= '0;
         h     <= '0;
      end else if (step) begin
         if (has_next) begin
            h <= h_next;
         end else begin
            h <= '0;
            if (!sb_last_x) begin
               sbx <= sbx + 1'b1;
            end else begin
               sbx <= '0;
               if (!sb_last_y) begin
                  sby <= sby + 1'b1;
               end else begin
                  sby <= '0;
                  case (plane)
                     PL_Y:    plane <= PL_CB;
                     PL_CB:   plane <= PL_CR;
                     default: begin
                        plane <= PL_Y;
                        coef  <= coef + 6'd1;
                     end
                  endcase
               end
            end
         end
      end
   end

   always_comb begin
      logic [3:0] xy;
      xy = hilbert_xy(h);
      bx = XW'(int'(sbx) * SB_SPAN + int'(xy[3:2]));
      by = YW'(int'(sby) * SB_SPAN + int'(xy[1:0]));
   end

   // R8: every accepted position lies inside the current plane
   p_in_plane_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> h_ok[h]);

   // R4: the coefficient index holds or rises by one between steps
   p_coef_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> ((coef == $past(coef)) || (coef == $past(coef) + 6'd1)));

endmodule

// File: rtl/toa_slot_map.sv
module toa_slot_map
   import toa_pkg::*;
#(
   parameter int MB_COLS = 5,
   parameter int MB_ROWS = 3,
   parameter int XW      = 4,
   parameter int YW      = 4,
   parameter int MB_IW   = 4
) (
   input  logic [XW-1:0]    bx,
   input  logic [YW-1:0]    by,
   input  plane_e           plane,
   output logic [MB_IW-1:0] mb,
   output logic [2:0]       sub
);

   always_comb begin
      int rt;
      if (plane == PL_Y) begin
         rt  = 2 * MB_ROWS - 1 - int'(by);
         mb  = MB_IW'((rt / 2) * MB_COLS + int'(bx) / 2);
         sub = 3'(2 * (rt % 2) + int'(bx[0]));
      end else begin
         rt  = MB_ROWS - 1 - int'(by);
         mb  = MB_IW'(rt * MB_COLS + int'(bx));
         sub = (plane == PL_CB) ? 3'd4 : 3'd5;
      end
   end

endmodule

// File: rtl/token_order_agu.sv
module token_order_agu
   import toa_pkg::*;
#(
   parameter int MB_COLS = 5,
   parameter int MB_ROWS = 3
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     start,
   input  logic                                     read_order,
   input  logic                                     ready,
   output logic                                     valid,
   output logic [$clog2(MB_COLS*MB_ROWS*384)-1:0]   slot_addr,
   output logic [5:0]                               coef_idx,
   output logic [1:0]                               plane,
   output logic                                     eof
);

   localparam int MB_TOTAL = MB_COLS * MB_ROWS;
   localparam int SLOTS    = MB_TOTAL * BLK_PER_MB * COEF_PER_BLK;
   localparam int AW       = $clog2(SLOTS);
   localparam int MB_IW    = (MB_TOTAL > 1) ? $clog2(MB_TOTAL) : 1;
   localparam int XW       = $clog2(2 * MB_COLS + SB_SPAN);
   localparam int YW       = $clog2(2 * MB_ROWS + SB_SPAN);

   if (MB_COLS < 1) begin : g_bad_cols
      $error("MB_COLS must be at least 1");
   end
   if (MB_ROWS < 1) begin : g_bad_rows
      $error("MB_ROWS must be at least 1");
   end

   logic busy, mode_rd, go, adv;
   logic w_last, r_last;
   logic [MB_IW-1:0] w_mb, r_mb, mb_sel;
   logic [2:0]       w_sub, r_sub, sub_sel;
   logic [5:0]       w_coef, r_coef;
   plane_e           w_plane, r_plane;
   logic [XW-1:0]    r_bx;
   logic [YW-1:0]    r_by;

   assign go  = start && !busy;
   assign adv = busy && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         mode_rd <= 1'b0;
      end else if (go) begin
         busy    <= 1'b1;
         mode_rd <= read_order;
      end else if (adv && eof) begin
         busy    <= 1'b0;
      end
   end

   toa_write_walk #(.MB_TOTAL(MB_TOTAL), .MB_IW(MB_IW)) u_wr (
      .clk(clk), .rst_n(rst_n), .init(go), .step(adv && !mode_rd),
      .mb(w_mb), .sub(w_sub), .coef(w_coef), .plane(w_plane), .last(w_last));

   toa_read_walk #(.MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .XW(XW), .YW(YW)) u_rd (
      .clk(clk), .rst_n(rst_n), .init(go), .step(adv && mode_rd),
      .coef(r_coef), .plane(r_plane), .bx(r_bx), .by(r_by), .last(r_last));

   toa_slot_map #(.MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .XW(XW), .YW(YW),
                  .MB_IW(MB_IW)) u_map (
      .bx(r_bx), .by(r_by), .plane(r_plane), .mb(r_mb), .sub(r_sub));

   assign mb_sel   = mode_rd ? r_mb   : w_mb;
   assign sub_sel  = mode_rd ? r_sub  : w_sub;
   assign coef_idx = mode_rd ? r_coef : w_coef;
   assign plane    = mode_rd ? r_plane : w_plane;
   assign valid    = busy;
   assign eof      = busy && (mode_rd ? r_last : w_last);
   assign slot_addr = AW'((int'(mb_sel) * BLK_PER_MB + int'(sub_sel)) * COEF_PER_BLK
                          + int'(coef_idx));

   // R9: a stalled address holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(slot_addr) && $stable(eof) && $stable(plane)));

   // R10: end flag only with a presented address
   p_eof_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> valid);

   // R10: valid falls after the last address is taken
   p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && eof) |=> !valid);

   // R3: write order is a plain increment
   p_write_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && !eof && !mode_rd) |=> (slot_addr == $past(slot_addr) + 1'b1));

   // R5: coefficient index stays put except across the Cr to Y wrap
   p_plane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && !eof && mode_rd && plane != 2'd2) |=> (coef_idx == $past(coef_idx)));

   // R11: address stays inside the buffer
   p_addr_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (int'(slot_addr) < SLOTS));

endmodule

// File: tb/token_order_agu_test.sv
`timescale 1ns/1ps
module token_order_agu_test;

   localparam int COLS = 5;
   localparam int ROWS = 3;
   localparam int N    = COLS * ROWS * 384;
   localparam int AW   = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic read_order = 1'b0;
   logic ready = 1'b0;
   logic valid, eof;
   logic [AW-1:0] slot_addr;
   logic [5:0] coef_idx;
   logic [1:0] plane;

   int applied = 0;
   int fails = 0;
   int k = 0;
   int poke_at = -1;

   always #2.5 clk = ~clk;

   token_order_agu #(.MB_COLS(COLS), .MB_ROWS(ROWS)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .read_order(read_order),
      .ready(ready), .valid(valid), .slot_addr(slot_addr), .coef_idx(coef_idx),
      .plane(plane), .eof(eof));

   function automatic int path_x(input int h);
      int t[16] = '{0,1,1,0,0,0,1,1,2,2,3,3,3,2,2,3};
      return t[h];
   endfunction
   function automatic int path_y(input int h);
      int t[16] = '{0,0,1,1,2,3,3,2,2,3,3,2,1,1,0,0};
      return t[h];
   endfunction

   task automatic chk(input bit ok, input string tg, input int act, input int exp);
      applied++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
      end
   endtask

   task automatic consume(input int ea, input int ec, input int ep,
                          input string tg, input int pct);
      bit done = 1'b0;
      while (!done) begin
         @(negedge clk);
         start = 1'b0;
         if (poke_at == k) begin
            start = 1'b1;       // R2: pulse while busy, with the other mode
            read_order = ~read_order;
         end
         ready = (($urandom % 100) < pct);
         if (!ready) begin
            chk(valid == 1'b1, "R9 valid during stall", int'(valid), 1);
            chk(int'(slot_addr) == ea, "R9 address held during stall", int'(slot_addr), ea);
         end else begin
            chk(valid == 1'b1, {tg, " valid"}, int'(valid), 1);
            chk(int'(slot_addr) == ea, {tg, "/R11 address"}, int'(slot_addr), ea);
            chk(int'(coef_idx) == ec, {tg, "/R4 coefficient"}, int'(coef_idx), ec);
            chk(int'(plane) == ep, {tg, "/R5 plane"}, int'(plane), ep);
            chk(eof == (k == N - 1), {tg, "/R10 eof"}, int'(eof), int'(k == N - 1));
            k++;
            done = 1'b1;
         end
      end
   endtask

   task automatic begin_frame(input bit rd);
      k = 0;
      @(negedge clk);
      read_order = rd;
      start = 1'b1;
   endtask

   task automatic end_frame();
      @(negedge clk);
      start = 1'b0;
      ready = 1'b0;
      chk(valid == 1'b0, "R10 idle after frame", int'(valid), 0);
      chk(k == N, "R10 address count", k, N);
   endtask

   task automatic write_frame(input int pct);
      begin_frame(1'b0);
      for (int mb = 0; mb < COLS * ROWS; mb++)
         for (int b = 0; b < 6; b++)
            for (int c = 0; c < 64; c++)
               consume((mb * 6 + b) * 64 + c, c, (b < 4) ? 0 : b - 3, "R3", pct);
      end_frame();
   endtask

   task automatic read_frame(input int pct, input int poke);
      poke_at = poke;
      begin_frame(1'b1);
      for (int c = 0; c < 64; c++) begin
         for (int p = 0; p < 3; p++) begin
            int w = (p == 0) ? 2 * COLS : COLS;
            int hgt = (p == 0) ? 2 * ROWS : ROWS;
            bit skipped = 1'b0;
            for (int sy = 0; sy < (hgt + 3) / 4; sy++) begin
               for (int sx = 0; sx < (w + 3) / 4; sx++) begin
                  for (int h = 0; h < 16; h++) begin
                     int x = sx * 4 + path_x(h);
                     int y = sy * 4 + path_y(h);
                     int rt, mb, sub;
                     string tg;
                     if (x >= w || y >= hgt) begin
                        skipped = 1'b1;   // R8: no address for this position
                        continue;
                     end
                     if (p == 0) begin
                        rt = 2 * ROWS - 1 - y;
                        mb = (rt / 2) * COLS + x / 2;
                        sub = 2 * (rt % 2) + (x % 2);
                     end else begin
                        rt = ROWS - 1 - y;
                        mb = rt * COLS + x;
                        sub = 3 + p;
                     end
                     if (poke >= 0 && k > poke) tg = "R2";
                     else if (skipped)          tg = "R8";
                     else if (p == 0)           tg = "R6";
                     else                       tg = "R7";
                     skipped = 1'b0;
                     consume((mb * 6 + sub) * 64 + c, c, p, tg, pct);
                  end
               end
            end
         end
      end
      poke_at = -1;
      end_frame();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
      chk(eof == 1'b0, "R1 eof in reset", int'(eof), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(valid == 1'b0, "R1 valid idle after reset", int'(valid), 0);
      chk(eof == 1'b0, "R1 eof idle after reset", int'(eof), 0);

      write_frame(75);
      read_frame(70, 1000);
      read_frame(100, -1);
      write_frame(100);
      read_frame(40, 5000);

      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog: actual frame still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
   end

endmodule